// File: doc/BRIEF.md
# Four-Entry Pairwise LRU Replacement Tracker

This block keeps the recency order of four translation-buffer entries. It stores one bit for each pair of entries, which gives six bits for four entries. Each bit records which entry of its pair was used less recently. When an entry is used, every pair bit that involves that entry is forced so that the entry becomes the most recent one. The bits of pairs that do not involve it keep their values. The victim for the next refill is decoded combinationally from fixed match patterns on the six bits.

Software can read the state at any time and can overwrite it. Codes that match no victim pattern are prohibited, but software can still write them. When the state holds such a code, the block raises a flag and points the victim at entry 0. A refill after a miss counts as a use of the victim chosen in that cycle. The block holds no tags, translations or entry contents.

Top module: `pair_lru_tracker`

## Requirements
- R1: While reset is low, the state reads 0. Reset is asynchronous and active low. From the zero state the victim is entry 3 and the illegal flag is low.
- R2: A software write loads the write data into the state on the next clock edge. The written value is then visible on the readback port.
- R3: Using entry 0 clears state bits 5, 4 and 3. Using entry 1 sets bit 5 and clears bits 2 and 1. Using entry 2 sets bits 4 and 2 and clears bit 0. Using entry 3 sets bits 3, 1 and 0. A use leaves every other bit unchanged and takes effect on the next clock edge.
- R4: The victim index is combinational from the state, as follows:
  - Entry 0 when bits 5, 4 and 3 are all 1.
  - Entry 1 when bit 5 is 0 and bits 2 and 1 are both 1.
  - Entry 2 when bits 4 and 2 are 0 and bit 0 is 1.
  - Entry 3 when bits 3, 1 and 0 are all 0.
- R5: The illegal flag is high exactly when the state matches none of the four R4 patterns. While the flag is high, the victim index is 0.
- R6: A refill strobe applies the R3 use pattern of the current victim to the state on the next clock edge.
- R7: When strobes coincide in one cycle, the order of precedence is software write, then refill, then use. Only the winning request changes the state.
- R8: With no write, refill or use strobe, the state holds its value. The use index has no effect unless the use strobe is high.
- R9: After reset, a sequence of hardware uses and refills never reaches an illegal state. After a hardware use or refill of an entry, that entry is no longer the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_valid | input | 1 | An entry was used this cycle |
| use_idx | input | 2 | Index of the used entry |
| sw_wr_en | input | 1 | Software write strobe for the state |
| sw_wr_data | input | 6 | Value written to the state |
| miss_refill | input | 1 | Refill of the current victim this cycle |
| state_q | output | 6 | Current pairwise state, for readback |
| victim_idx | output | 2 | Entry to replace on the next refill |
| illegal | output | 1 | State matches no victim pattern |

## Verification
The assertions check the following on every cycle:
- The reset value of the state.
- Software writes landing on the next edge.
- The state holding while no strobe is present.
- The default victim under an illegal code.
- At most one entry matching a victim pattern.
- A used or refilled entry leaving the victim slot.
- No illegal code appearing before any software write.

The exact per-bit effect of each use, the full victim decode across all 64 codes, and the precedence between coinciding strobes can only be shown by the bench's scenarios. The bench sweeps every state against every entry and strobe type. It compares the results with bit masks it derives itself.

// File: rtl/pair_lru_pkg.sv
package pair_lru_pkg;

  // Which request updates the state in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_USE  = 2'd1,
    SRC_FILL = 2'd2,
    SRC_SW   = 2'd3
  } upd_src_e;

  // Number of entry pairs for n entries
  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction

  // Bit position of pair (a,b), a < b. Pairs are ranked (0,1),(0,2),...,(n-2,n-1)
  // and the first pair in that ranking sits at the top bit.
  function automatic int pair_pos(input int n, input int a, input int b);
    int rank;
    rank = (a * (2 * n - a - 1)) / 2 + (b - a - 1);
    return pair_count(n) - 1 - rank;
  endfunction

endpackage

// File: rtl/plru_touch.sv
// Next state after an entry is used: the entry becomes younger than every other.
// A pair bit of 1 means the lower-numbered entry of the pair is the older one.
module plru_touch
  import pair_lru_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N),
  parameter int ST_W  = (N * (N - 1)) / 2
) (
  input  logic [ST_W-1:0]  cur,
  input  logic [IDX_W-1:0] idx,
  output logic [ST_W-1:0]  nxt
);

  for (genvar a = 0; a < N; a++) begin : g_lo
    for (genvar b = a + 1; b < N; b++) begin : g_hi
      localparam int POS = pair_pos(N, a, b);
      assign nxt[POS] = (idx == IDX_W'(a)) ? 1'b0 :
                        (idx == IDX_W'(b)) ? 1'b1 : cur[POS];
    end
  end

endmodule

// File: rtl/plru_victim.sv
// Victim decode: an entry is the victim when it is older than every other entry.
module plru_victim
  import pair_lru_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N),
  parameter int ST_W  = (N * (N - 1)) / 2
) (
  input  logic [ST_W-1:0]  st,
  output logic [N-1:0]     lru,
  output logic [IDX_W-1:0] victim,
  output logic             none
);

  logic m;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      m = 1'b1;
      for (int o = 0; o < N; o++) begin
        if (o < e)      m = m & ~st[pair_pos(N, o, e)];
        else if (o > e) m = m &  st[pair_pos(N, e, o)];
      end
      lru[e] = m;
    end
  end

  // Patterns are mutually exclusive; with no match the victim falls back to 0.
  always_comb begin
    victim = '0;
    for (int e = N - 1; e >= 0; e--) begin
      if (lru[e]) victim = IDX_W'(e);
    end
  end

  assign none = ~|lru;

endmodule

// File: rtl/pair_lru_tracker.sv
module pair_lru_tracker
  import pair_lru_pkg::*;
#(
  parameter  int NUM_ENTRIES = 4,
  localparam int IDX_W       = $clog2(NUM_ENTRIES),
  localparam int ST_W        = (NUM_ENTRIES * (NUM_ENTRIES - 1)) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_valid,
  input  logic [IDX_W-1:0] use_idx,
  input  logic             sw_wr_en,
  input  logic [ST_W-1:0]  sw_wr_data,
  input  logic             miss_refill,
  output logic [ST_W-1:0]  state_q,
  output logic [IDX_W-1:0] victim_idx,
  output logic             illegal
);

  upd_src_e               upd_src;
  logic [IDX_W-1:0]       touch_idx;
  logic [ST_W-1:0]        touched;
  logic [ST_W-1:0]        state_d;
  logic [NUM_ENTRIES-1:0] entry_lru;

  // Precedence: software write, then refill, then use
  always_comb begin
    if (sw_wr_en)         upd_src = SRC_SW;
    else if (miss_refill) upd_src = SRC_FILL;
    else if (use_valid)   upd_src = SRC_USE;
    else                  upd_src = SRC_NONE;
  end

  assign touch_idx = (upd_src == SRC_FILL) ? victim_idx : use_idx;

  plru_touch #(
    .N     (NUM_ENTRIES),
    .IDX_W (IDX_W),
    .ST_W  (ST_W)
  ) u_touch (
    .cur (state_q),
    .idx (touch_idx),
    .nxt (touched)
  );

  always_comb begin
    unique case (upd_src)
      SRC_SW:            state_d = sw_wr_data;
      SRC_FILL, SRC_USE: state_d = touched;
      default:           state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  plru_victim #(
    .N     (NUM_ENTRIES),
    .IDX_W (IDX_W),
    .ST_W  (ST_W)
  ) u_victim (
    .st     (state_q),
    .lru    (entry_lru),
    .victim (victim_idx),
    .none   (illegal)
  );

endmodule

// File: rtl/pair_lru_checker.sv
module pair_lru_checker #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N),
  parameter int ST_W  = (N * (N - 1)) / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             use_valid,
  input logic [IDX_W-1:0] use_idx,
  input logic             sw_wr_en,
  input logic [ST_W-1:0]  sw_wr_data,
  input logic             miss_refill,
  input logic [ST_W-1:0]  state_q,
  input logic [IDX_W-1:0] victim_idx,
  input logic             illegal,
  input logic [N-1:0]     entry_lru
);

  // Set once software has written the state since reset
  logic sw_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_seen <= 1'b0;
    else if (sw_wr_en) sw_seen <= 1'b1;
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> state_q == '0);

  a_r2_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> state_q == $past(sw_wr_data));

  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_lru));

  a_r5_default_victim: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> victim_idx == '0);

  a_r6_fill_leaves_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_refill && !sw_wr_en) |=> (illegal || victim_idx != $past(victim_idx)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && !miss_refill && !use_valid) |=> $stable(state_q));

  a_r9_use_leaves_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid && !miss_refill && !sw_wr_en) |=> (illegal || victim_idx != $past(use_idx)));

  a_r9_hw_stays_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_seen |-> !illegal);

endmodule

bind pair_lru_tracker pair_lru_checker #(
  .N     (NUM_ENTRIES),
  .IDX_W (IDX_W),
  .ST_W  (ST_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .use_valid   (use_valid),
  .use_idx     (use_idx),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_data  (sw_wr_data),
  .miss_refill (miss_refill),
  .state_q     (state_q),
  .victim_idx  (victim_idx),
  .illegal     (illegal),
  .entry_lru   (entry_lru)
);

// File: tb/pair_lru_tracker_bench.sv
`timescale 1ns/1ps
module pair_lru_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       use_valid = 1'b0;
  logic [1:0] use_idx = '0;
  logic       sw_wr_en = 1'b0;
  logic [5:0] sw_wr_data = '0;
  logic       miss_refill = 1'b0;
  logic [5:0] state_q;
  logic [1:0] victim_idx;
  logic       illegal;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pair_lru_tracker u_pair_lru_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_valid   (use_valid),
    .use_idx     (use_idx),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_data  (sw_wr_data),
    .miss_refill (miss_refill),
    .state_q     (state_q),
    .victim_idx  (victim_idx),
    .illegal     (illegal)
  );

  // Bench model: use of an entry, as set and clear masks
  function automatic logic [5:0] model_use(input logic [5:0] s, input int i);
    case (i)
      0:       return s & 6'b000111;
      1:       return (s | 6'b100000) & 6'b111001;
      2:       return (s | 6'b010100) & 6'b111110;
      default: return s | 6'b001011;
    endcase
  endfunction

  // Bench model: victim index, or -1 for an illegal code
  function automatic int model_victim(input logic [5:0] s);
    if (s[5] && s[4] && s[3])        return 0;
    if (!s[5] && s[2] && s[1])       return 1;
    if (!s[4] && !s[2] && s[0])      return 2;
    if (!s[3] && !s[1] && !s[0])     return 3;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of strobes from a falling edge; return at the next falling edge
  task automatic drive(input logic w, input logic [5:0] wd, input logic u,
                       input logic [1:0] ui, input logic m);
    sw_wr_en = w; sw_wr_data = wd; use_valid = u; use_idx = ui; miss_refill = m;
    @(negedge clk);
    sw_wr_en = 1'b0; use_valid = 1'b0; miss_refill = 1'b0;
  endtask

  task automatic load(input logic [5:0] s);
    drive(1'b1, s, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] s;
    int v;
    int ex;
    repeat (3) @(negedge clk);
    chk("R1", "state in reset", int'(state_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset", int'(state_q), 0);
    chk("R1", "victim after reset", int'(victim_idx), 3);
    chk("R1", "illegal after reset", int'(illegal), 0);

    // R2, R4, R5: every code written, read back and decoded
    for (int c = 0; c < 64; c++) begin
      load(6'(c));
      chk("R2", "readback", int'(state_q), c);
      v  = model_victim(6'(c));
      ex = (v < 0) ? 0 : v;
      chk("R4", "victim decode", int'(victim_idx), ex);
      chk("R5", "illegal flag", int'(illegal), (v < 0) ? 1 : 0);
    end

    // R3: every code against every use
    for (int c = 0; c < 64; c++) begin
      for (int i = 0; i < 4; i++) begin
        load(6'(c));
        drive(1'b0, 6'd0, 1'b1, 2'(i), 1'b0);
        chk("R3", "use update", int'(state_q), int'(model_use(6'(c), i)));
      end
    end

    // R6: refill of every code, illegal ones included (victim defaults to 0)
    for (int c = 0; c < 64; c++) begin
      load(6'(c));
      v = model_victim(6'(c));
      if (v < 0) v = 0;
      drive(1'b0, 6'd0, 1'b0, 2'd0, 1'b1);
      chk("R6", "refill update", int'(state_q), int'(model_use(6'(c), v)));
    end

    // R7: precedence between coinciding strobes
    load(6'b000000);
    drive(1'b1, 6'b010101, 1'b1, 2'd3, 1'b1);
    chk("R7", "write over refill and use", int'(state_q), 6'b010101);
    load(6'b000000);
    drive(1'b0, 6'd0, 1'b1, 2'd0, 1'b1);
    chk("R7", "refill over use", int'(state_q), 6'b001011);
    load(6'b111000);
    drive(1'b0, 6'd0, 1'b1, 2'd3, 1'b1);
    chk("R7", "refill of 0 over use of 3", int'(state_q), 6'b000000);

    // R8: idle cycles with a changing use index
    load(6'b101010);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 6'b111111, 1'b0, 2'(k), 1'b0);
      chk("R8", "hold without strobe", int'(state_q), 6'b101010);
    end

    // R9: hardware-only walk from reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    s = 6'b000000;
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 4) == 0) begin
        v = model_victim(s);
        drive(1'b0, 6'd0, 1'b0, 2'd0, 1'b1);
      end else begin
        v = int'($urandom % 4);
        drive(1'b0, 6'd0, 1'b1, 2'(v), 1'b0);
      end
      s = model_use(s, (v < 0) ? 0 : v);
      chk("R9", "walk state", int'(state_q), int'(s));
      chk("R9", "walk legal", int'(illegal), 0);
      n_tests++;
      if (int'(victim_idx) == v) begin
        n_fail++;
        $display("FAIL R9 touched entry still victim: actual %0d expected not %0d",
                 victim_idx, v);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule